// File: doc/BRIEF.md
# Operand-Isolated Low-Power ALU

This block is a 32-bit arithmetic and logic unit split into four independent functional units: an adder/subtractor, a bitwise boolean unit, a barrel shifter and a comparator. Each unit has its own holding register in front of it, which captures the operands and the in-unit operation code. That register captures only in a cycle where a valid request is addressed to that unit. Every other unit keeps its previous inputs exactly, so its internal nodes do not switch and it draws no dynamic power. This matters most for the shifter: it is large and rarely used.

A request is one cycle with `in_valid` high, carrying a 4-bit opcode and two operands. The upper two opcode bits name the unit and the lower two bits choose the operation inside it. The answer appears one clock later with `result_valid` high for one cycle. A registered copy of the unit number steers the output multiplexer, so the answer always comes from the unit that was loaded. A one-hot strobe per unit reports the cycles in which that unit's holding register captures, so switching activity can be counted from outside.

Top module: `lpalu_top`

## Requirements
- R1: While reset is asserted and after its release with no request, `result` is 0, `result_valid` is 0 and `unit_load` is 0.
- R2: Opcode bits [3:2] select the unit: 00 arithmetic, 01 boolean, 10 shift, 11 compare. In a cycle with `in_valid` high, `unit_load` has exactly bit [3:2] set, and in a cycle with `in_valid` low it is all zeros.
- R3: `result_valid` is high in the cycle that follows a cycle with `in_valid` high, and low in the cycle that follows a cycle with `in_valid` low.
- R4: Arithmetic unit: opcode bit 0 clear gives a+b and bit 0 set gives a-b, both modulo 2^32 (low codes 00/10 add, 01/11 subtract).
- R5: Boolean unit: low code 00 gives AND, 01 gives OR, 10 gives XOR, 11 gives NOR.
- R6: Shift unit: the amount is `opb[4:0]` and the upper bits of `opb` are ignored. Low code 00 shifts left logically, 01 shifts right logically, 10 shifts right arithmetically, and 11 returns 0.
- R7: Compare unit: low code 00 tests equality, 01 tests signed less-than and 10 tests unsigned less-than, with the answer 1 or 0 zero-extended to 32 bits. Code 11 returns 0.
- R8: In a cycle that follows a cycle with `in_valid` low, `result` holds the last answer unchanged, whatever the operand and opcode inputs do.
- R9: A unit's holding register changes only in a cycle in which its `unit_load` bit is high. Over a run, the number of strobes per unit equals the number of requests sent to that unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 4 | [3:2] unit, [1:0] operation inside the unit |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B (shift amount in [4:0]) |
| result | output | 32 | Answer of the most recently loaded unit |
| result_valid | output | 1 | One-cycle flag marking a fresh answer |
| unit_load | output | 4 | Per-unit capture strobe, bit index equals unit code |

## Verification
A holding register that captured in the wrong cycle would make `result` move while no request is pending, or would make an answer come from stale operands. Either shows up in the first cycle after the faulty capture. A wrong unit-number register sends another unit's answer to the output in the very cycle `result_valid` rises. A decode fault shows as a `unit_load` pattern that differs from the opcode in the request cycle itself. A holding register that captures in the background, without changing any answer, cannot be seen at the ports. The in-register stability property covers that case, and the bench checks the per-unit strobe totals.

// File: rtl/lpalu_pkg.sv
package lpalu_pkg;

   localparam int NUM_UNITS = 4;
   localparam int SUBOP_W   = 2;

   // unit codes as carried in opcode[3:2]
   localparam int KIND_ARITH = 0;
   localparam int KIND_BOOL  = 1;
   localparam int KIND_SHIFT = 2;
   localparam int KIND_CMP   = 3;

   typedef enum logic [1:0] {
      UNIT_ARITH = 2'd0,
      UNIT_BOOL  = 2'd1,
      UNIT_SHIFT = 2'd2,
      UNIT_CMP   = 2'd3
   } unit_e;

endpackage

// File: rtl/lpalu_hold.sv
module lpalu_hold #(
   parameter int DATA_W = 32,
   parameter int OP_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [OP_W-1:0]   op_d,
   input  logic [DATA_W-1:0] a_d,
   input  logic [DATA_W-1:0] b_d,
   output logic [OP_W-1:0]   op_q,
   output logic [DATA_W-1:0] a_q,
   output logic [DATA_W-1:0] b_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q <= '0;
         a_q  <= '0;
         b_q  <= '0;
      end else if (load) begin
         op_q <= op_d;
         a_q  <= a_d;
         b_q  <= b_d;
      end
   end

   // R9: frozen inputs for an unselected unit
   a_r9_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable({op_q, a_q, b_q}));

   // R9: a capture takes the presented operands
   a_r9_capture : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (a_q == $past(a_d)) && (b_q == $past(b_d)));

endmodule

// File: rtl/lpalu_fu.sv
module lpalu_fu #(
   parameter int DATA_W = 32,
   parameter int KIND   = 0,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   generate
      if (KIND == lpalu_pkg::KIND_ARITH) begin : g_arith
         always_comb y = op[0] ? (a - b) : (a + b);
         logic unused_op;
         assign unused_op = op[1];
      end else if (KIND == lpalu_pkg::KIND_BOOL) begin : g_bool
         always_comb begin
            case (op)
               2'd0:    y = a & b;
               2'd1:    y = a | b;
               2'd2:    y = a ^ b;
               default: y = ~(a | b);
            endcase
         end
      end else if (KIND == lpalu_pkg::KIND_SHIFT) begin : g_shift
         logic [SH_W-1:0] amt;
         assign amt = b[SH_W-1:0];
         always_comb begin
            case (op)
               2'd0:    y = a << amt;
               2'd1:    y = a >> amt;
               2'd2:    y = DATA_W'($signed(a) >>> amt);
               default: y = '0;
            endcase
         end
         logic unused_b;
         assign unused_b = ^b[DATA_W-1:SH_W];
      end else begin : g_cmp
         logic hit;
         always_comb begin
            case (op)
               2'd0:    hit = (a == b);
               2'd1:    hit = ($signed(a) < $signed(b));
               2'd2:    hit = (a < b);
               default: hit = 1'b0;
            endcase
            y = {{(DATA_W-1){1'b0}}, hit};
         end
      end
   endgenerate

endmodule

// File: rtl/lpalu_top.sv
module lpalu_top #(
   parameter int DATA_W = 32,
   localparam int NU    = lpalu_pkg::NUM_UNITS,
   localparam int OP_W  = lpalu_pkg::SUBOP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        opcode,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] result,
   output logic              result_valid,
   output logic [NU-1:0]     unit_load
);

   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("lpalu_top: DATA_W must be a power of two of at least 2");
      end
   endgenerate

   lpalu_pkg::unit_e unit_sel, sel_q;
   logic [OP_W-1:0]  sub_op;
   logic             rv_q;
   logic [DATA_W-1:0] fu_y [NU];

   assign unit_sel = lpalu_pkg::unit_e'(opcode[3:2]);
   assign sub_op   = opcode[OP_W-1:0];

   generate
      for (genvar i = 0; i < NU; i++) begin : g_unit
         logic [OP_W-1:0]   h_op;
         logic [DATA_W-1:0] h_a, h_b;

         assign unit_load[i] = in_valid && (unit_sel == lpalu_pkg::unit_e'(i));

         lpalu_hold #(.DATA_W(DATA_W), .OP_W(OP_W)) u_hold (
            .clk  (clk),
            .rst_n(rst_n),
            .load (unit_load[i]),
            .op_d (sub_op),
            .a_d  (opa),
            .b_d  (opb),
            .op_q (h_op),
            .a_q  (h_a),
            .b_q  (h_b)
         );

         lpalu_fu #(.DATA_W(DATA_W), .KIND(i)) u_fu (
            .op(h_op),
            .a (h_a),
            .b (h_b),
            .y (fu_y[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= lpalu_pkg::UNIT_ARITH;
         rv_q  <= 1'b0;
      end else begin
         rv_q <= in_valid;
         if (in_valid) sel_q <= unit_sel;
      end
   end

   assign result       = fu_y[sel_q];
   assign result_valid = rv_q;

   // R2: at most one unit captures per cycle
   a_r2_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(unit_load));

   // R2: no capture without a request
   a_r2_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (unit_load == '0));

   // R3: answer flag one cycle after a request
   a_r3_latency : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> result_valid);

   // R3: no flag without a request
   a_r3_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !result_valid);

   // R8: output held across idle cycles
   a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   // R7: comparator answer is a single bit
   a_r7_cmp_width : assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && sel_q == lpalu_pkg::UNIT_CMP) |-> (result[DATA_W-1:1] == '0));

endmodule

// File: tb/lpalu_top_tb.sv
module lpalu_top_tb;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   opcode = '0;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic [W-1:0] result;
   logic         result_valid;
   logic [3:0]   unit_load;

   always #4 clk = ~clk;

   lpalu_top #(.DATA_W(W)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .opcode      (opcode),
      .opa         (opa),
      .opb         (opb),
      .result      (result),
      .result_valid(result_valid),
      .unit_load   (unit_load)
   );

   typedef struct {
      logic [3:0]   op;
      logic [W-1:0] val;
   } exp_t;

   exp_t         exp_q[$];
   int           checks = 0;
   int           errors = 0;
   logic         exp_rv = 1'b0;
   logic [W-1:0] last_res = '0;
   int           drv_cnt[4] = '{0, 0, 0, 0};
   int           obs_cnt[4] = '{0, 0, 0, 0};

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %08h expected %08h", req, what, act, expv);
      end
   endtask

   function automatic logic [W-1:0] model(input logic [3:0] op,
                                          input logic [W-1:0] a, input logic [W-1:0] b);
      logic [4:0] sh;
      sh = b[4:0];
      case (op[3:2])
         2'd0: return op[0] ? a - b : a + b;
         2'd1: case (op[1:0])
                  2'd0: return a & b;
                  2'd1: return a | b;
                  2'd2: return a ^ b;
                  default: return ~(a | b);
               endcase
         2'd2: case (op[1:0])
                  2'd0: return a << sh;
                  2'd1: return a >> sh;
                  2'd2: return W'($signed(a) >>> sh);
                  default: return '0;
               endcase
         default: case (op[1:0])
                  2'd0: return {31'd0, a == b};
                  2'd1: return {31'd0, $signed(a) < $signed(b)};
                  2'd2: return {31'd0, a < b};
                  default: return '0;
               endcase
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] op);
      case (op[3:2])
         2'd0: return "R4";
         2'd1: return "R5";
         2'd2: return "R6";
         default: return "R7";
      endcase
   endfunction

   // expected answer flag: request seen at the previous edge
   always @(posedge clk) exp_rv <= rst_n & in_valid;

   // monitor: samples at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(result_valid == exp_rv, "R3", "result_valid", W'(result_valid), W'(exp_rv));
         chk(unit_load == (in_valid ? 4'(1 << opcode[3:2]) : 4'd0), "R2", "unit_load",
             W'(unit_load), in_valid ? W'(1 << opcode[3:2]) : '0);
         for (int i = 0; i < 4; i++) if (unit_load[i]) obs_cnt[i]++;
         if (result_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3", "answer without request", result, '0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(result == e.val, req_of(e.op), "result", result, e.val);
               last_res = result;
            end
         end else begin
            chk(result == last_res, "R8", "held result", result, last_res);
         end
      end
   end

   task automatic issue(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
      @(posedge clk);
      #1;
      in_valid = 1'b1;
      opcode   = op;
      opa      = a;
      opb      = b;
      exp_q.push_back('{op: op, val: model(op, a, b)});
      drv_cnt[op[3:2]]++;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
         in_valid = 1'b0;
         opcode   = 4'($urandom);
         opa      = $urandom;
         opb      = $urandom;
      end
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual expired expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(result == '0, "R1", "result in reset", result, '0);
      chk(result_valid == 1'b0, "R1", "result_valid in reset", W'(result_valid), '0);
      chk(unit_load == 4'd0, "R1", "unit_load in reset", W'(unit_load), '0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(result == '0, "R1", "result after release", result, '0);

      // R4: add and subtract with wrap
      issue(4'h0, 32'hFFFF_FFFF, 32'h1);
      issue(4'h1, 32'h0, 32'h1);
      issue(4'h2, 32'h1234_5678, 32'h1111_1111);
      issue(4'h3, 32'h8000_0000, 32'h1);
      // R5: boolean ops
      issue(4'h4, 32'hF0F0_FF00, 32'h0FF0_F0F0);
      issue(4'h5, 32'hF0F0_FF00, 32'h0FF0_F0F0);
      issue(4'h6, 32'hF0F0_FF00, 32'h0FF0_F0F0);
      issue(4'h7, 32'hF0F0_FF00, 32'h0FF0_F0F0);
      idle(3);
      // R6: shifts, amount from low five bits only
      issue(4'h8, 32'h0000_0001, 32'd31);
      issue(4'h9, 32'h8000_0000, 32'hFFFF_FFE4);
      issue(4'hA, 32'h8000_0010, 32'h25);
      issue(4'hA, 32'h4000_0000, 32'd30);
      issue(4'hB, 32'hDEAD_BEEF, 32'd3);
      idle(2);
      // R7: compares
      issue(4'hC, 32'hCAFE_0001, 32'hCAFE_0001);
      issue(4'hC, 32'hCAFE_0001, 32'hCAFE_0002);
      issue(4'hD, 32'hFFFF_FFFF, 32'h1);
      issue(4'hE, 32'hFFFF_FFFF, 32'h1);
      issue(4'hD, 32'h7FFF_FFFF, 32'h8000_0000);
      issue(4'hE, 32'h1, 32'hFFFF_FFFF);
      issue(4'hF, 32'h1, 32'h2);
      idle(4);
      // mixed traffic with gaps
      for (int n = 0; n < 300; n++) begin
         issue(4'($urandom), $urandom, $urandom);
         if ($urandom_range(3) == 0) idle($urandom_range(1, 3));
      end
      idle(4);

      chk(exp_q.size() == 0, "R3", "answers outstanding", W'(exp_q.size()), '0);
      // R9: capture strobes match requests per unit
      for (int i = 0; i < 4; i++)
         chk(obs_cnt[i] == drv_cnt[i], "R9", $sformatf("strobes unit %0d", i),
             W'(obs_cnt[i]), W'(drv_cnt[i]));
      finish_run();
   end

endmodule